// File: doc/BRIEF.md
# Byte-Command I2C Master

This block drives an I2C bus as master, one byte at a time. Software writes the byte into the data register and then writes a control word. When that word has both the core-enable and the transfer-enable bits set, the block runs one byte on the bus. Three flags in the same word can add a START or repeated START before the byte, a STOP after its acknowledge slot, or a not-acknowledge from the master in place of the usual ACK. After each byte software polls the status register. That register shows whether a byte went out, whether a byte came in, and whether the acknowledge slot was high.

The SCL rate is set by an 18-bit divider COUNT and a glitch-suppression term GSR. One SCL period lasts 2*(COUNT+2)+GSR clock cycles: the low half is COUNT+2 cycles and the high half is COUNT+2+GSR cycles. A setup/hold field TSR is stored next to GSR. A self-clearing soft reset aborts the current transfer and returns the bus to idle. Both bus lines are open-drain. Each is modelled as a pull-down enable, and SDA also has an input sample.

Register offsets (bus_addr): 0 control, 1 status, 2 data, 3 divider COUNT, 4 timing (GSR in bits 7:0, TSR in bits 15:8). Control bits: 0 soft reset, 1 core enable, 2 transfer enable, 3 START, 4 STOP, 5 NAK. Status bits: 0 byte transmitted, 1 byte received, 2 acknowledge slot high, 3 busy.

Top module: `i2c_byte_master`

## Requirements
- R1: With SCL running, the time from one SCL rise to the next is 2*(COUNT+2)+GSR clock cycles for every COUNT and GSR setting.
- R2: The divider register keeps 18 bits, so writing 0x7FFFF reads back 0x3FFFF. The timing register reads back GSR in bits 7:0 and TSR in bits 15:8, and TSR=32 is a legal value.
- R3: Writing control bit 0 starts a soft reset. Control bit 0 then reads 1 for 4 cycles and clears by itself. The reset releases SCL and SDA, clears the status register and leaves the engine idle.
- R4: A control write starts a byte only if bit 1 (enable) and bit 2 (transfer enable) are both 1. If either is 0, the bus stays idle and the status register does not change.
- R5: With START (bit 3) set, SDA falls while SCL is high before the byte. If the bus is being held after an earlier byte, the block issues a repeated START.
- R6: Bytes go out MSB first. SDA changes only while SCL is low, except during START and STOP, and the slave sees each written byte exactly.
- R7: A transmitted byte sets status bit 0. After a START byte whose bit 0 is 1, every later byte without START is a receive. A received byte is placed in the data register and sets status bit 1. Status bits 0 to 2 clear when the next byte starts.
- R8: A receive commanded with NAK (bit 5) and STOP (bit 4) leaves SDA high in the acknowledge slot and then issues STOP. It sets status bits 1 and 2.
- R9: With STOP set, a STOP condition follows the byte's acknowledge slot and the bus is released. Without STOP, SCL is held low after the byte.
- R10: If SDA is high in the acknowledge slot of a transmitted byte (no slave responded), status bits 0 and 2 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (the PCLK of the SCL formula) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 18 | Write data |
| bus_rdata | output | 18 | Read data for bus_addr (combinational) |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The hardest state to reach is a byte that ends with the bus held. It is followed by a repeated START and a change of direction, and then by a receive that ends in a master NAK and a STOP. The stimulus reaches this state only by sending a full register-pointer write first, so the bench uses a behavioural slave. The slave holds a small memory, acknowledges its own address, and returns data MSB first. It counts the STARTs and STOPs it detects and the ACKs and NAKs it gets from the master. A soft reset fired mid-byte toward an absent address shows that the bus recovers.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_RSLO, S_STA, S_STB, S_BLO, S_BHI, S_SPA, S_SPB, S_SPC
  } eng_st_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_DATA = 3'd2;
  localparam logic [2:0] A_DIV  = 3'd3;
  localparam logic [2:0] A_TIME = 3'd4;

  localparam int CB_RST = 0;
  localparam int CB_EN  = 1;
  localparam int CB_XEN = 2;
  localparam int CB_STA = 3;
  localparam int CB_STO = 4;
  localparam int CB_NAK = 5;
endpackage

// File: rtl/i2cb_seg_timer.sv
module i2cb_seg_timer #(
  parameter int DIV_W = 18,
  parameter int GSR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             nxt_hi,
  input  logic             nxt_short,
  input  logic [DIV_W-1:0] div_cnt,
  input  logic [GSR_W-1:0] gsr,
  output logic             seg_done
);
  localparam int TW = DIV_W + 2;

  logic [TW-1:0] cnt_q, cnt_d, seg_len;

  assign seg_done = (cnt_q == '0);

  always_comb begin
    seg_len = TW'(div_cnt) + TW'(2) + (nxt_hi ? TW'(gsr) : '0);
    if (clr)            cnt_d = '0;
    else if (seg_done)  cnt_d = nxt_short ? '0 : seg_len - TW'(1);
    else                cnt_d = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1)));
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       go,
  input  logic       c_sta,
  input  logic       c_sto,
  input  logic       c_nak,
  input  logic [7:0] tx_byte,
  input  logic       seg_done,
  input  logic       sda_i,
  output logic       nxt_hi,
  output logic       nxt_short,
  output logic       idle,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       done,
  output logic       rx_flag,
  output logic       nak_flag,
  output logic [7:0] rx_byte
);
  eng_st_t    st_q, st_d;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       smp_q, nak_q, rdm_q, f_sto_q, f_nak_q, f_rx_q;
  logic       last;

  assign last = (bit_q == 4'd8);

  always_comb begin
    st_d = st_q;
    if (seg_done) begin
      case (st_q)
        S_IDLE:  if (go) st_d = c_sta ? S_STA  : S_BLO;
        S_HOLD:  if (go) st_d = c_sta ? S_RSLO : S_BLO;
        S_RSLO:  st_d = S_STA;
        S_STA:   st_d = S_STB;
        S_STB:   st_d = S_BLO;
        S_BLO:   st_d = S_BHI;
        S_BHI:   st_d = !last ? S_BLO : (f_sto_q ? S_SPA : S_HOLD);
        S_SPA:   st_d = S_SPB;
        S_SPB:   st_d = S_SPC;
        S_SPC:   st_d = S_IDLE;
        default: st_d = S_IDLE;
      endcase
    end
    if (srst) st_d = S_IDLE;
  end

  assign nxt_hi    = st_d inside {S_STA, S_STB, S_BHI, S_SPB, S_SPC};
  assign nxt_short = st_d inside {S_IDLE, S_HOLD};
  assign idle      = st_q inside {S_IDLE, S_HOLD};
  assign scl_oe    = st_q inside {S_HOLD, S_RSLO, S_BLO, S_SPA};
  assign done      = seg_done && !srst &&
                     ((st_q == S_BHI && last && !f_sto_q) || st_q == S_SPC);

  always_comb begin
    case (st_q)
      S_STB, S_SPA, S_SPB: sda_oe = 1'b1;
      S_BLO, S_BHI:        sda_oe = !last ? (!f_rx_q && !sh_q[7]) : (f_rx_q && !f_nak_q);
      default:             sda_oe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; bit_q <= '0; sh_q <= '0; smp_q <= 1'b0; nak_q <= 1'b0;
      rdm_q <= 1'b0; f_sto_q <= 1'b0; f_nak_q <= 1'b0; f_rx_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (srst) begin
        rdm_q <= 1'b0;
        bit_q <= '0;
      end else if (go) begin
        bit_q   <= '0;
        sh_q    <= tx_byte;
        f_sto_q <= c_sto;
        f_nak_q <= c_nak;
        f_rx_q  <= !c_sta && rdm_q;
        if (c_sta) rdm_q <= tx_byte[0];
      end else if (seg_done && st_q == S_BLO) begin
        if (!last) smp_q <= sda_i;
        else       nak_q <= sda_i;
      end else if (seg_done && st_q == S_BHI && !last) begin
        sh_q  <= {sh_q[6:0], smp_q};
        bit_q <= bit_q + 4'd1;
      end
    end
  end

  assign rx_flag  = f_rx_q;
  assign nak_flag = nak_q;
  assign rx_byte  = sh_q;

  p_sda_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BHI && $past(st_q) == S_BHI) |-> $stable(sda_oe));
  p_start_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && $rose(sda_oe)) |-> (st_q == S_STB));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cb_pkg::*;
#(
  parameter int DIV_W      = 18,
  parameter int GSR_W      = 8,
  parameter int TSR_W      = 8,
  parameter int RST_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [DIV_W-1:0] bus_wdata,
  output logic [DIV_W-1:0] bus_rdata,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_i
);
  localparam int BW  = DIV_W;
  localparam int RCW = $clog2(RST_CYCLES + 1);

  logic [7:0]       data_q, data_d;
  logic [DIV_W-1:0] div_q;
  logic [GSR_W-1:0] gsr_q;
  logic [TSR_W-1:0] tsr_q;
  logic             dt_q, dr_q, nakc_q, dt_d, dr_d, nakc_d;
  logic [RCW-1:0]   rcnt_q, rcnt_d;
  logic             srst, wr_ctrl, go, e_idle, e_done, e_rx, e_nak;
  logic             seg_done, nxt_hi, nxt_short;
  logic [7:0]       e_rxb;

  assign srst    = (rcnt_q != '0);
  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign go      = wr_ctrl && !bus_wdata[CB_RST] && bus_wdata[CB_EN] &&
                   bus_wdata[CB_XEN] && e_idle && !srst;

  i2cb_seg_timer #(.DIV_W(DIV_W), .GSR_W(GSR_W)) u_tmr (
    .clk, .rst_n, .clr(srst), .nxt_hi, .nxt_short,
    .div_cnt(div_q), .gsr(gsr_q), .seg_done
  );

  i2cb_engine u_eng (
    .clk, .rst_n, .srst, .go,
    .c_sta(bus_wdata[CB_STA]), .c_sto(bus_wdata[CB_STO]), .c_nak(bus_wdata[CB_NAK]),
    .tx_byte(data_q), .seg_done, .sda_i, .nxt_hi, .nxt_short,
    .idle(e_idle), .scl_oe, .sda_oe, .done(e_done),
    .rx_flag(e_rx), .nak_flag(e_nak), .rx_byte(e_rxb)
  );

  always_comb begin
    rcnt_d = rcnt_q;
    if (wr_ctrl && bus_wdata[CB_RST]) rcnt_d = RCW'(RST_CYCLES);
    else if (srst)                    rcnt_d = rcnt_q - RCW'(1);
    {dt_d, dr_d, nakc_d} = {dt_q, dr_q, nakc_q};
    if (srst || go)  {dt_d, dr_d, nakc_d} = 3'b000;
    else if (e_done) {dt_d, dr_d, nakc_d} = {!e_rx, e_rx, e_nak};
    data_d = data_q;
    if (e_done && e_rx)                   data_d = e_rxb;
    else if (bus_wr && bus_addr == A_DATA) data_d = bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0; dt_q <= 1'b0; dr_q <= 1'b0; nakc_q <= 1'b0;
      data_q <= '0; div_q <= '0; gsr_q <= '0; tsr_q <= '0;
    end else begin
      rcnt_q <= rcnt_d;
      dt_q   <= dt_d;
      dr_q   <= dr_d;
      nakc_q <= nakc_d;
      data_q <= data_d;
      if (bus_wr && bus_addr == A_DIV) div_q <= bus_wdata;
      if (bus_wr && bus_addr == A_TIME) begin
        gsr_q <= bus_wdata[GSR_W-1:0];
        tsr_q <= bus_wdata[GSR_W +: TSR_W];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[0] = srst;
      A_STAT: bus_rdata[3:0] = {!e_idle, nakc_q, dr_q, dt_q};
      A_DATA: bus_rdata[7:0] = data_q;
      A_DIV:  bus_rdata = div_q;
      A_TIME: bus_rdata[GSR_W+TSR_W-1:0] = {tsr_q, gsr_q};
      default: bus_rdata = '0;
    endcase
  end

  p_status_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dt_q && dr_q));
  p_srst_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!scl_oe && !sda_oe));
  p_bw_fits_r2: assert final (BW >= GSR_W + TSR_W);
endmodule

// File: tb/sim_i2c_byte_master.sv
module sim_i2c_byte_master;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, bus_wr, trk_clr;
  logic [2:0]  bus_addr;
  logic [17:0] bus_wdata;
  logic [17:0] bus_rdata;
  logic        scl_oe, sda_oe, s_drv;
  logic        scl_line, sda_line;
  int total, bad;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || s_drv);

  i2c_byte_master u0 (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .scl_oe, .sda_oe, .sda_i(sda_line)
  );

  // behavioural slave at address 0x50
  logic [7:0] s_mem [4];
  logic [7:0] s_sh, s_txb, s_ptr;
  logic [3:0] s_bit;
  int         s_bidx, s_starts, s_stops, s_macks, s_mnaks;
  logic       s_sel, s_rw, s_send, s_mnak, p_scl, p_sda;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) s_mem[i] <= 8'h00;
      s_sh <= 0; s_txb <= 0; s_ptr <= 0; s_bit <= 0; s_bidx <= 0;
      s_starts <= 0; s_stops <= 0; s_macks <= 0; s_mnaks <= 0;
      s_sel <= 0; s_rw <= 0; s_send <= 0; s_mnak <= 0; s_drv <= 0;
      p_scl <= 1; p_sda <= 1;
    end else begin
      p_scl <= scl_line; p_sda <= sda_line;
      if (p_scl && scl_line && p_sda && !sda_line) begin
        s_starts <= s_starts + 1; s_bit <= 0; s_bidx <= 0; s_sel <= 0;
        s_send <= 0; s_mnak <= 0; s_drv <= 0;
      end else if (p_scl && scl_line && !p_sda && sda_line) begin
        s_stops <= s_stops + 1; s_sel <= 0; s_drv <= 0;
      end else if (!p_scl && scl_line) begin
        if (s_bit < 8) begin
          logic [7:0] b;
          b = {s_sh[6:0], sda_line};
          s_sh <= b; s_bit <= s_bit + 1;
          if (s_bit == 7) begin
            if (s_bidx == 0) begin s_sel <= (b[7:1] == 7'h50); s_rw <= b[0]; end
            else if (s_sel && !s_rw) begin
              if (s_bidx == 1) s_ptr <= b;
              else begin s_mem[s_ptr[1:0]] <= b; s_ptr <= s_ptr + 1; end
            end
            s_bidx <= s_bidx + 1;
          end
        end else begin
          if (s_send) begin
            if (sda_line) begin s_mnaks <= s_mnaks + 1; s_mnak <= 1; end
            else s_macks <= s_macks + 1;
            s_ptr <= s_ptr + 1;
          end
          s_bit <= 0;
        end
      end else if (p_scl && !scl_line) begin
        if (s_bit == 0) begin
          if (s_sel && s_rw && s_bidx >= 1 && !s_mnak) begin
            s_send <= 1; s_txb <= s_mem[s_ptr[1:0]]; s_drv <= !s_mem[s_ptr[1:0]][7];
          end else begin s_send <= 0; s_drv <= 0; end
        end else if (s_bit < 8) s_drv <= s_send ? !s_txb[7 - s_bit] : 1'b0;
        else s_drv <= !s_send && s_sel && (s_bidx == 1 || !s_rw);
      end
    end
  end

  // SCL rise-to-rise interval tracker
  int cyc, last_rise, pmin, pmax;
  logic have_ref, t_pscl;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    t_pscl <= scl_line;
    if (trk_clr) begin have_ref <= 0; pmin <= 1 << 30; pmax <= 0; end
    else if (!t_pscl && scl_line) begin
      if (have_ref) begin
        if (cyc - last_rise < pmin) pmin <= cyc - last_rise;
        if (cyc - last_rise > pmax) pmax <= cyc - last_rise;
      end
      have_ref <= 1; last_rise <= cyc;
    end
  end

  localparam logic [17:0] C_GO = 18'h6, C_STA = 18'h8, C_STO = 18'h10, C_NAK = 18'h20;
  localparam int NV = 4;
  // {COUNT[17:0], GSR[7:0], reg[7:0], data[7:0]}
  localparam logic [41:0] VEC [NV] = '{
    {18'd0, 8'd0, 8'h00, 8'h5A},
    {18'd3, 8'd0, 8'h01, 8'hC3},
    {18'd2, 8'd5, 8'h02, 8'h01},
    {18'd7, 8'd3, 8'h03, 8'hFE}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [17:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [17:0] v);
    @(negedge clk); bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [17:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd1, v);
      if (!v[3]) break;
    end
  endtask

  task automatic cmd(input logic [7:0] d, input logic [17:0] fl);
    wr(3'd2, {10'd0, d});
    @(negedge clk); trk_clr = 1;
    @(negedge clk); trk_clr = 0;
    wr(3'd0, C_GO | fl);
    wait_idle();
  endtask

  logic [17:0] v;
  int st0, sp0, ma0, mn0;

  initial begin
    total = 0; bad = 0; rst_n = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; trk_clr = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    trk_clr = 0;
    // reset state
    rd(3'd1, v); chk("R3 reset status", v, 0);
    rd(3'd0, v); chk("R3 reset ctrl", v, 0);
    chk("R3 reset lines", {scl_oe, sda_oe}, 0);
    // register widths
    wr(3'd3, 18'h3FFFF); rd(3'd3, v); chk("R2 div max", v, 18'h3FFFF);
    wr(3'd4, {2'b0, 8'd32, 8'd5}); rd(3'd4, v); chk("R2 timing tsr32", v, 18'h2005);

    // table: write one register per vector under a different SCL setting
    for (int k = 0; k < NV; k++) begin
      logic [17:0] c; logic [7:0] g, r, d;
      {c, g, r, d} = VEC[k];
      wr(3'd3, c); wr(3'd4, {2'b0, 8'd32, g});
      sp0 = s_stops;
      cmd(8'hA0, C_STA);
      rd(3'd1, v); chk("R7 dt after address", v[2:0], 3'b001);
      chk("R9 scl held low without stop", scl_oe, 1);
      cmd(r, 0);
      cmd(d, C_STO);
      chk("R1 scl period min", pmin, 2 * (c + 2) + g);
      chk("R1 scl period max", pmax, 2 * (c + 2) + g);
      chk("R9 stop seen", s_stops - sp0, 1);
      chk("R9 bus released", {scl_oe, sda_oe}, 0);
      chk("R6 slave byte", s_mem[r[1:0]], d);
    end

    // read with repeated start, ACK then NAK+STOP
    st0 = s_starts; sp0 = s_stops; ma0 = s_macks; mn0 = s_mnaks;
    cmd(8'hA0, C_STA);
    cmd(8'h01, 0);
    cmd(8'hA1, C_STA);
    chk("R5 repeated start count", s_starts - st0, 2);
    wr(3'd2, 18'h0);
    wr(3'd0, C_GO);
    rd(3'd1, v); chk("R7 status cleared at start", v[2:0], 0);
    wait_idle();
    rd(3'd1, v); chk("R7 dr on receive", v[2:0], 3'b010);
    rd(3'd2, v); chk("R7 received byte", v, 8'hC3);
    cmd(8'h00, C_NAK | C_STO);
    rd(3'd1, v); chk("R8 dr and ack flag", v[2:0], 3'b110);
    rd(3'd2, v); chk("R8 last byte", v, 8'h01);
    chk("R8 master ack count", s_macks - ma0, 1);
    chk("R8 master nak count", s_mnaks - mn0, 1);
    chk("R8 stop after nak", s_stops - sp0, 1);

    // absent slave
    cmd(8'hA2, C_STA | C_STO);
    rd(3'd1, v); chk("R10 no ack seen", v[2:0], 3'b101);

    // commands without both enables are ignored
    st0 = s_starts;
    wr(3'd0, 18'h0A);
    wr(3'd0, 18'h0C);
    repeat (30) @(negedge clk);
    rd(3'd1, v); chk("R4 status kept", v, 18'h5);
    chk("R4 no start", s_starts - st0, 0);
    chk("R4 lines idle", {scl_oe, sda_oe}, 0);

    // soft reset in the middle of a byte
    wr(3'd2, 18'hA2);
    wr(3'd0, C_GO | C_STA | C_STO);
    repeat (20) @(negedge clk);
    wr(3'd0, 18'h1);
    rd(3'd0, v); chk("R3 reset bit busy", v, 1);
    repeat (6) @(negedge clk);
    rd(3'd0, v); chk("R3 reset bit cleared", v, 0);
    rd(3'd1, v); chk("R3 status cleared idle", v, 0);
    chk("R3 lines released", {scl_oe, sda_oe}, 0);
    cmd(8'hA0, C_STA); cmd(8'h02, 0); cmd(8'h77, C_STO);
    chk("R3 recovery write", s_mem[2], 8'h77);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule